// File: doc/BRIEF.md
# Two-Mode Serial ADC Frame Reader

This block is the host side of a link to a single serial analog-to-digital converter that has two ways of running its conversion. A one-cycle `start` request, together with `mode_int`, makes the reader take one sample. It first sets the serial clock to an idle level that picks the mode. It then lowers chip select and clocks in one 16-bit frame. It checks the frame's fixed leading bits and hands back the channel bit and the 12-bit result.

In self-timed mode (`mode_int` = 1) the converter uses its own oscillator. The reader gives one falling clock edge to start the conversion, then watches the data line until the converter pulls it high to report that the conversion is finished. In host-clocked mode (`mode_int` = 0) the reader's own clock drives the conversion, so the clock runs without pause from chip-select fall to the last bit.

The clock half-period, the setup time, the wait limit for the end-of-conversion flag and the minimum chip-select high time are all parameters. Results come out together with a one-cycle `done` pulse on the same edge that releases chip select.

Top module: `sadc_reader`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `cs_n`=1, `sclk`=0, `busy`=0, `done`=0, `err_hdr`=0, `err_tmo`=0, `chan_id`=0 and `result`=0.
- R2: Before `cs_n` falls, `sclk` is driven high when `mode_int`=1 (self-timed) and low when `mode_int`=0 (host-clocked). That level is held for at least SETUP_CLKS cycles before the fall and does not change on the fall.
- R3: While `cs_n` is low, exactly 16 rising `sclk` edges occur in a complete frame, and every high phase that follows a rise lasts DIV_CLKS cycles. `sdata` passes through a SYNC_STAGES-flop synchroniser and is sampled on each rise, which requires DIV_CLKS >= SYNC_STAGES+2.
- R4: In self-timed mode, `sclk` falls DIV_CLKS cycles after `cs_n` falls. It then stays low, with no rising edge, until `sdata` has been seen high.
- R5: Frame bits are counted in arrival order. Bits 1 to 3 form the header, bit 4 drives `chan_id`, and bits 5 to 16 drive `result` with the first of them as its MSB. In host-clocked mode `done` rises exactly SETUP_CLKS+(2*16+1)*DIV_CLKS cycles after the edge that samples `start`.
- R6: `err_hdr`=1 exactly when any of the three header bits is 0. `chan_id` and `result` still carry the captured bits in that case.
- R7: If `sdata` is not seen high within EOC_TMO_CLKS cycles after the self-timed start edge, the reader raises `cs_n` and gives `done` with `err_tmo`=1, `err_hdr`=0, `chan_id`=0 and `result`=0. In that frame no rising `sclk` edge occurs while `cs_n` is low.
- R8: `done` is high for exactly one cycle, on the same edge on which `cs_n` returns high. `result`, `chan_id`, `err_hdr` and `err_tmo` hold their values until the next `done`.
- R9: `busy` rises on the edge that samples `start` and falls GAP_CLKS cycles after `done`. Between two frames `cs_n` stays high for at least GAP_CLKS+SETUP_CLKS cycles.
- R10: A `start` that arrives while `busy`=1 is ignored and does not begin a later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to read one conversion |
| mode_int | input | 1 | 1 = self-timed conversion, 0 = host-clocked conversion; sampled with `start` |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | A read is in progress or the release gap is running |
| done | output | 1 | One-cycle pulse when new results are valid |
| chan_id | output | 1 | Channel bit from frame bit 4 |
| result | output | RES_W | Conversion result, MSB first in the frame |
| err_hdr | output | 1 | Header bits were not all one |
| err_tmo | output | 1 | End-of-conversion flag did not arrive in time |

## Verification
In host-clocked mode `done` is due a fixed SETUP_CLKS+(2*16+1)*DIV_CLKS cycles after the sampling edge of `start`, and the bench checks that count exactly. A timeout `done` is due SETUP_CLKS+DIV_CLKS+EOC_TMO_CLKS cycles after that edge, and is also checked exactly. In self-timed mode the delay adds the converter's conversion time plus up to a few cycles of synchroniser and detection latency, so the bench accepts a narrow window above the host-clocked figure. The bench counts cycles at falling clock edges, reads outputs only there, and checks that `done` drops on the next cycle and that `busy` drops GAP_CLKS cycles after `done`.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int HDR_W = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_WAKE,
    S_POLL,
    S_LOW,
    S_HIGH,
    S_TAIL,
    S_GAP
  } rd_state_t;
endpackage

// File: rtl/sadc_timer.sv
module sadc_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= '0;
    else     ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame #(
  parameter int RES_W = 12,
  localparam int FRAME_W = sadc_pkg::HDR_W + 1 + RES_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift,
  input  logic             bit_in,
  output logic             hdr_bad,
  output logic             chan,
  output logic [RES_W-1:0] res
);
  logic [FRAME_W-1:0] sh;
  logic [sadc_pkg::HDR_W-1:0] hdr;

  always_ff @(posedge clk) begin
    if (rst || clr) sh <= '0;
    else if (shift) sh <= {sh[FRAME_W-2:0], bit_in};
  end

  assign hdr     = sh[FRAME_W-1 -: sadc_pkg::HDR_W];
  assign hdr_bad = ~&hdr;
  assign chan    = sh[RES_W];
  assign res     = sh[RES_W-1:0];
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
  import sadc_pkg::*;
#(
  parameter int RES_W        = 12,
  parameter int DIV_CLKS     = 4,
  parameter int SETUP_CLKS   = 3,
  parameter int EOC_TMO_CLKS = 256,
  parameter int GAP_CLKS     = 5,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_int,
  input  logic             sdata,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic             done,
  output logic             chan_id,
  output logic [RES_W-1:0] result,
  output logic             err_hdr,
  output logic             err_tmo
);
  localparam int FRAME_W = HDR_W + 1 + RES_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int MAX_A   = (DIV_CLKS > SETUP_CLKS) ? DIV_CLKS : SETUP_CLKS;
  localparam int MAX_B   = (EOC_TMO_CLKS > GAP_CLKS) ? EOC_TMO_CLKS : GAP_CLKS;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW      = $clog2(MAX_C + 1);

  rd_state_t        st, st_n;
  logic             mode_q, mode_n;
  logic [CNT_W-1:0] bit_cnt;
  logic             tz, ld;
  logic [TW-1:0]    ld_val;
  logic             sd_s;
  logic             sclk_n, cs_n_n;
  logic             shift_en, enter_gap, enter_setup;
  logic             fr_bad, fr_chan;
  logic [RES_W-1:0] fr_res;

  sadc_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(ld), .val(ld_val), .zero(tz)
  );

  sadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(sdata), .q(sd_s)
  );

  sadc_frame #(.RES_W(RES_W)) u_frame (
    .clk(clk), .rst(rst), .clr(enter_setup), .shift(shift_en),
    .bit_in(sd_s), .hdr_bad(fr_bad), .chan(fr_chan), .res(fr_res)
  );

  // next state and timer reload
  always_comb begin
    st_n   = st;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st)
      S_IDLE: if (start) begin
        st_n = S_SETUP; ld = 1'b1; ld_val = TW'(SETUP_CLKS - 1);
      end
      S_SETUP: if (tz) begin
        st_n = mode_q ? S_WAKE : S_LOW; ld = 1'b1; ld_val = TW'(DIV_CLKS - 1);
      end
      S_WAKE: if (tz) begin
        st_n = S_POLL; ld = 1'b1; ld_val = TW'(EOC_TMO_CLKS - 1);
      end
      S_POLL: begin
        if (sd_s) begin
          st_n = S_LOW; ld = 1'b1; ld_val = TW'(DIV_CLKS - 1);
        end else if (tz) begin
          st_n = S_GAP; ld = 1'b1; ld_val = TW'(GAP_CLKS - 1);
        end
      end
      S_LOW: if (tz) begin
        st_n = S_HIGH; ld = 1'b1; ld_val = TW'(DIV_CLKS - 1);
      end
      S_HIGH: if (tz) begin
        st_n = (bit_cnt == CNT_W'(FRAME_W)) ? S_TAIL : S_LOW;
        ld = 1'b1; ld_val = TW'(DIV_CLKS - 1);
      end
      S_TAIL: if (tz) begin
        st_n = S_GAP; ld = 1'b1; ld_val = TW'(GAP_CLKS - 1);
      end
      S_GAP: if (tz) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  assign mode_n      = (st == S_IDLE) ? mode_int : mode_q;
  assign enter_setup = (st == S_IDLE) && (st_n == S_SETUP);
  assign enter_gap   = (st != S_GAP) && (st_n == S_GAP);
  assign shift_en    = (st == S_LOW) && (st_n == S_HIGH);

  // pin levels follow the state being entered, so the pins stay registered
  always_comb begin
    unique case (st_n)
      S_SETUP: sclk_n = mode_n;
      S_WAKE:  sclk_n = 1'b1;
      S_HIGH:  sclk_n = 1'b1;
      default: sclk_n = 1'b0;
    endcase
    cs_n_n = (st_n == S_IDLE) || (st_n == S_SETUP) || (st_n == S_GAP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      mode_q  <= 1'b0;
      bit_cnt <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      chan_id <= 1'b0;
      result  <= '0;
      err_hdr <= 1'b0;
      err_tmo <= 1'b0;
    end else begin
      st   <= st_n;
      cs_n <= cs_n_n;
      sclk <= sclk_n;
      busy <= (st_n != S_IDLE);
      done <= enter_gap;
      if (enter_setup) begin
        mode_q  <= mode_int;
        bit_cnt <= '0;
      end else if (shift_en) begin
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (enter_gap) begin
        if (st == S_POLL) begin
          err_tmo <= 1'b1;
          err_hdr <= 1'b0;
          chan_id <= 1'b0;
          result  <= '0;
        end else begin
          err_tmo <= 1'b0;
          err_hdr <= fr_bad;
          chan_id <= fr_chan;
          result  <= fr_res;
        end
      end
    end
  end
endmodule

// File: rtl/sadc_reader_chk.sv
module sadc_reader_chk #(
  parameter int RES_W    = 12,
  parameter int DIV_CLKS = 4,
  parameter int GAP_CLKS = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             mode_int,
  input logic             busy,
  input logic             cs_n,
  input logic             sclk,
  input logic             done,
  input logic             err_tmo,
  input logic [RES_W-1:0] result
);
  localparam int FRAME_W = sadc_pkg::HDR_W + 1 + RES_W;
  localparam int HW = $clog2(DIV_CLKS + 2) + 1;
  localparam int RW = $clog2(FRAME_W + 2) + 1;
  localparam int GW = $clog2(GAP_CLKS + 1) + 1;

  logic          cap_mode, sclk_q, cs_q, armed;
  logic [HW-1:0] hi_cnt;
  logic [RW-1:0] rcnt;
  logic [GW-1:0] hcnt;
  logic          rise;

  assign rise = sclk && !sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_mode <= 1'b0;
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      armed    <= 1'b0;
      hi_cnt   <= '0;
      rcnt     <= '0;
      hcnt     <= GW'(GAP_CLKS);
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (start && !busy) cap_mode <= mode_int;
      if (cs_n)      armed <= 1'b0;
      else if (rise) armed <= 1'b1;
      if (rise)                       hi_cnt <= HW'(1);
      else if (sclk && hi_cnt != '1)  hi_cnt <= hi_cnt + 1'b1;
      else if (!sclk)                 hi_cnt <= '0;
      if (cs_q && !cs_n)                   rcnt <= '0;
      else if (rise && !cs_n && rcnt != '1) rcnt <= rcnt + 1'b1;
      if (!cs_n)                          hcnt <= '0;
      else if (hcnt < GW'(GAP_CLKS))      hcnt <= hcnt + 1'b1;
    end
  end

  p_mode_lvl_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (sclk == cap_mode) && $stable(sclk));

  p_half_period_r3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && armed && sclk_q && !sclk) |-> (hi_cnt == HW'(DIV_CLKS)));

  p_rise_count_r3: assert property (@(posedge clk) disable iff (rst)
    (done && !err_tmo) |-> (rcnt == RW'(FRAME_W)));

  p_tmo_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (done && err_tmo) |-> (result == '0) && (rcnt == '0));

  p_done_release_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> done);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_cs_gap_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hcnt >= GW'(GAP_CLKS)));
endmodule

bind sadc_reader sadc_reader_chk #(
  .RES_W(RES_W), .DIV_CLKS(DIV_CLKS), .GAP_CLKS(GAP_CLKS)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode_int(mode_int), .busy(busy),
  .cs_n(cs_n), .sclk(sclk), .done(done), .err_tmo(err_tmo), .result(result)
);

// File: tb/sadc_reader_tb.sv
module sadc_reader_tb;
  localparam int RES_W = 12;
  localparam int DIV   = 4;
  localparam int SETUP = 3;
  localparam int TMO   = 256;
  localparam int GAP   = 5;
  localparam int FW    = 16;
  localparam int EXT_LAT = SETUP + (2 * FW + 1) * DIV + 1;
  localparam int NV = 8;
  // {mode_int, header[2:0], chan, data[11:0]}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 3'b111, 1'b0, 12'hA5C},
    {1'b1, 3'b111, 1'b1, 12'h3F1},
    {1'b0, 3'b111, 1'b1, 12'hFFF},
    {1'b1, 3'b111, 1'b0, 12'h000},
    {1'b0, 3'b011, 1'b1, 12'h123},
    {1'b0, 3'b110, 1'b0, 12'h800},
    {1'b0, 3'b101, 1'b1, 12'h001},
    {1'b1, 3'b111, 1'b1, 12'h7FE}
  };

  logic clk = 0, rst = 1, start = 0, mode_int = 0, sdata = 0;
  logic cs_n, sclk, busy, done, chan_id, err_hdr, err_tmo;
  logic [RES_W-1:0] result;

  always #10 clk = ~clk;

  sadc_reader #(.RES_W(RES_W), .DIV_CLKS(DIV), .SETUP_CLKS(SETUP),
                .EOC_TMO_CLKS(TMO), .GAP_CLKS(GAP), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode_int(mode_int), .sdata(sdata),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .done(done), .chan_id(chan_id),
    .result(result), .err_hdr(err_hdr), .err_tmo(err_tmo)
  );

  // converter model and pin monitor: picks its mode from sclk at the chip-select fall
  logic [15:0] m_frame = '0;
  int m_conv = 10;
  logic p_cs = 1, p_sclk = 0, m_int = 0, m_started = 0, m_ready = 0, fall_sclk = 0;
  int m_idx = 0, m_cnt = -1;
  int rise_cnt = 0, early_rise = 0, lvl_cnt = 0, lvl_at_fall = 0;
  int since_fall = 0, wake_cyc = 0, n_falls = 0;

  always @(negedge clk) begin
    lvl_cnt    <= (sclk != p_sclk) ? 1 : lvl_cnt + 1;
    since_fall <= since_fall + 1;
    if (p_cs && !cs_n) begin
      m_int <= sclk; m_idx <= 0; m_started <= 0; m_cnt <= -1; m_ready <= !sclk;
      sdata <= sclk ? 1'b0 : m_frame[15];
      rise_cnt <= 0; early_rise <= 0; fall_sclk <= sclk; lvl_at_fall <= lvl_cnt;
      since_fall <= 0; n_falls <= n_falls + 1;
    end else if (!p_cs && cs_n) begin
      sdata <= 1'b0;
    end else if (!cs_n) begin
      if (!p_sclk && sclk) begin
        rise_cnt <= rise_cnt + 1;
        if (!m_ready) early_rise <= early_rise + 1;
      end
      if (p_sclk && !sclk) begin
        if (m_int && !m_started) begin
          m_started <= 1; m_cnt <= m_conv; wake_cyc <= since_fall + 1;
        end else begin
          m_idx <= m_idx + 1;
          sdata <= (m_idx < 15) ? m_frame[14 - m_idx] : 1'b0;
        end
      end else if (m_cnt > 0) begin
        m_cnt <= m_cnt - 1;
      end else if (m_cnt == 0) begin
        sdata <= m_frame[15]; m_cnt <= -1; m_ready <= 1;
      end
    end
    p_cs <= cs_n; p_sclk <= sclk;
  end

  int checks = 0, errors = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // called at a falling edge; returns at the falling edge where done is seen
  task automatic run_frame(input logic md, input logic [15:0] fr, input int conv, output int lat);
    m_frame = fr; m_conv = conv; mode_int = md; start = 1; lat = 0;
    @(negedge clk); start = 0; lat = 1;
    chk("R9", "busy after start", busy, 1);
    while (!done && lat < 4000) begin
      @(negedge clk); lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors + 1);
    $finish;
  end

  initial begin
    int lat, hold;
    logic [RES_W-1:0] r_keep;
    repeat (4) @(negedge clk);
    chk("R1", "cs_n in reset", cs_n, 1);
    chk("R1", "sclk in reset", sclk, 0);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "done in reset", done, 0);
    chk("R1", "err_hdr/err_tmo in reset", {err_hdr, err_tmo}, 0);
    chk("R1", "result/chan in reset", {chan_id, result}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "cs_n after reset", cs_n, 1);
    chk("R1", "sclk after reset", sclk, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic md;
      md = VEC[i][16];
      run_frame(md, VEC[i][15:0], 30, lat);
      chk("R5", "result", result, VEC[i][11:0]);
      chk("R5", "chan_id", chan_id, VEC[i][12]);
      chk("R6", "err_hdr", err_hdr, (VEC[i][15:13] != 3'b111) ? 1 : 0);
      chk("R7", "err_tmo clear", err_tmo, 0);
      chk("R8", "cs_n high with done", cs_n, 1);
      chk("R3", "rising edges", rise_cnt, FW);
      chk("R2", "sclk level at cs fall", fall_sclk, md);
      chk_rng("R2", "level held before cs fall", lvl_at_fall, SETUP, 100000);
      if (md) begin
        chk("R4", "wake fall delay", wake_cyc, DIV);
        chk("R4", "rises before flag", early_rise, 0);
        chk_rng("R5", "self-timed latency", lat, EXT_LAT + DIV + 30, EXT_LAT + DIV + 36);
      end else begin
        chk("R5", "host-clocked latency", lat, EXT_LAT);
      end
      r_keep = result;
      @(negedge clk);
      chk("R8", "done one cycle", done, 0);
      repeat (GAP) @(negedge clk);
      chk("R9", "busy drop after gap", busy, 0);
      chk("R8", "result held", result, r_keep);
    end

    // timeout: flag never arrives
    run_frame(1'b1, 16'hFFFF, -1, lat);
    chk("R7", "err_tmo", err_tmo, 1);
    chk("R7", "result cleared", result, 0);
    chk("R7", "chan cleared", chan_id, 0);
    chk("R7", "err_hdr clear", err_hdr, 0);
    chk("R7", "no rises", rise_cnt, 0);
    chk("R7", "timeout latency", lat, SETUP + DIV + TMO + 1);
    chk("R8", "cs_n high on timeout", cs_n, 1);
    repeat (GAP + 1) @(negedge clk);

    // recovery frame after a timeout
    run_frame(1'b0, VEC[0][15:0], 0, lat);
    chk("R7", "recovery result", result, VEC[0][11:0]);
    chk("R7", "recovery err_tmo", err_tmo, 0);
    repeat (GAP + 1) @(negedge clk);

    // start while busy is ignored (during frame and during gap)
    begin
      int falls0;
      m_frame = VEC[2][15:0]; m_conv = 30; mode_int = 0; start = 1;
      @(negedge clk); start = 0;
      repeat (20) @(negedge clk);
      mode_int = 1; start = 1;
      @(negedge clk); start = 0;
      hold = 0;
      while (!done && hold < 4000) begin @(negedge clk); hold++; end
      chk("R10", "result with mid-frame start", result, VEC[2][11:0]);
      falls0 = n_falls;
      start = 1;
      @(negedge clk); start = 0;
      repeat (GAP + SETUP + 30) @(negedge clk);
      chk("R10", "no frame from ignored starts", n_falls, falls0);
      chk("R10", "idle after ignored starts", busy, 0);
    end

    // start held through the gap: chip select high time
    run_frame(1'b0, VEC[6][15:0], 0, lat);
    start = 1; mode_int = 0; m_frame = VEC[0][15:0];
    hold = 0;
    while (cs_n && hold < 4000) begin @(negedge clk); hold++; end
    start = 0;
    chk_rng("R9", "cs_n high between frames", hold, GAP + SETUP, GAP + SETUP + 3);
    hold = 0;
    while (!done && hold < 4000) begin @(negedge clk); hold++; end
    chk("R5", "back-to-back result", result, VEC[0][11:0]);
    repeat (GAP + 2) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule